// File: doc/BRIEF.md
# Dual-Threshold Latched Trip Controller

This block turns two digital comparator outputs, both taken from the same analog quantity, into a latched trip flag with hysteresis that needs no software. One input is asserted while the signal is above a high threshold. A run-length filter qualifies that input, and once it is qualified it sets a sticky trip flag. The other input comes from a comparator on a lower threshold. While the signal is under that lower level, an event stage emits single-cycle synchronization pulses, and each pulse clears the trip flag.

The event stage has two behaviours. In edge mode it pulses once, when the low-side condition becomes active. In window mode it pulses on activation and then again each time a programmable blanking window runs out, for as long as the condition stays active. A static input therefore keeps re-issuing resets. The pulse is also driven out of the block so that it can be routed as a synchronization event elsewhere. A parameter selects whether the low-side input arrives as a raw comparator output (high above the low threshold, inverted inside the block) or is already active-below.

Top module: `dual_thresh_trip`

## Requirements
- R1: While `rst_n` is low at a clock edge, `trip_o` and `sync_o` become 0 whatever the inputs, and the filter count, the filtered level, the window timer and the edge history are cleared.
- R2: `hi_cmp_i` is qualified only after N consecutive samples differing from the current filtered level, with N = `cfg_filt_len` (1..255, 0 acts as 1). `trip_o` rises on the edge after qualification, which is the (N+1)th edge counting from the first edge that samples the input high. Shorter high runs never set `trip_o`.
- R3: Once set, `trip_o` stays 1 after `hi_cmp_i` falls, until a sync pulse clears it.
- R4: With `LO_ACTIVE_BELOW = 0`, the low-side condition is active while `lo_cmp_i` is 0. `sync_o` can be 1 only in the cycle after an edge that sampled the condition active.
- R5: With `cfg_blank_mode = 0` (edge mode), `sync_o` is a single one-cycle pulse, raised by the edge that first samples the condition active. No further pulse follows while the condition stays active.
- R6: With `cfg_blank_mode = 1` (window mode) and window length L = `cfg_blank_len`, `sync_o` pulses on the first active edge and then every L+1 cycles while the condition stays active. L = 0 gives a pulse on every cycle.
- R7: In window mode, a condition that goes inactive cancels the running window. The next activation pulses at once.
- R8: A pulse on `sync_o` clears `trip_o` at the next edge, even when the filtered high input is asserting set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_filt_len | input | FILT_W | Required run length of the high-side filter |
| cfg_blank_mode | input | 1 | 0: edge-only events, 1: repeating blanking-window events |
| cfg_blank_len | input | WIN_W | Blanking window length L in cycles |
| hi_cmp_i | input | 1 | High-threshold comparator, 1 above the high level |
| lo_cmp_i | input | 1 | Low-threshold comparator, polarity set by LO_ACTIVE_BELOW |
| trip_o | output | 1 | Latched trip flag |
| sync_o | output | 1 | One-cycle reset and synchronization pulse |

## Verification
A filter count stuck or off by one moves the rising edge of `trip_o` by whole cycles against the N+1 edge rule, or lets a short high run trip the flag. Both show at the ports within a few cycles of the stimulus. A wrong window timer shifts the period of the repeated `sync_o` pulses, or lets a pulse survive a deactivation, so the expected pulse train is checked cycle by cycle. Priority errors in the latch show as `trip_o` still high in the cycle right after a pulse that coincides with a qualified high input.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
   typedef enum logic {
      EVT_EDGE   = 1'b0,
      EVT_WINDOW = 1'b1
   } evt_mode_e;
endpackage

// File: rtl/dtt_filter.sv
module dtt_filter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] run_len,
   input  logic         din,
   output logic         qual
);
   logic [W-1:0] cnt;
   logic [W:0]   need;
   logic [W:0]   nxt;

   assign need = (run_len == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, run_len};
   assign nxt  = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qual <= 1'b0;
         cnt  <= '0;
      end else if (din == qual) begin
         cnt <= '0;
      end else if (nxt >= need) begin
         qual <= din;
         cnt  <= '0;
      end else begin
         cnt <= nxt[W-1:0];
      end
   end
endmodule

// File: rtl/dtt_sync_gen.sv
module dtt_sync_gen
   import dtt_pkg::*;
#(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  evt_mode_e        mode,
   input  logic [WIN_W-1:0] win_len,
   output logic             pulse
);
   logic             act_d;
   logic [WIN_W-1:0] tmr;
   logic             fire;

   assign fire = act & ((mode == EVT_WINDOW) ? (tmr == '0) : !act_d);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_d <= 1'b0;
         pulse <= 1'b0;
         tmr   <= '0;
      end else begin
         act_d <= act;
         pulse <= fire;
         if (!act || mode == EVT_EDGE) begin
            tmr <= '0;
         end else if (fire) begin
            tmr <= win_len;
         end else if (tmr != '0) begin
            tmr <= tmr - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dtt_trip_latch.sv
module dtt_trip_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (clr) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end
   end
endmodule

// File: rtl/dual_thresh_trip.sv
module dual_thresh_trip
   import dtt_pkg::*;
#(
   parameter int FILT_W          = 8,
   parameter int WIN_W           = 16,
   parameter bit LO_ACTIVE_BELOW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILT_W-1:0] cfg_filt_len,
   input  logic              cfg_blank_mode,
   input  logic [WIN_W-1:0]  cfg_blank_len,
   input  logic              hi_cmp_i,
   input  logic              lo_cmp_i,
   output logic              trip_o,
   output logic              sync_o
);
   localparam int FILT_MAX = (1 << FILT_W) - 1;

   if (FILT_W < 1 || FILT_W > 16) begin : g_bad_filt_w
      $error("dual_thresh_trip: FILT_W out of range");
   end
   if (WIN_W < 1 || WIN_W > 32) begin : g_bad_win_w
      $error("dual_thresh_trip: WIN_W out of range");
   end
   if (FILT_MAX < 1) begin : g_bad_filt_max
      $error("dual_thresh_trip: filter length range empty");
   end

   logic      hi_qual;
   logic      lo_act;
   evt_mode_e evt_mode;

   if (LO_ACTIVE_BELOW) begin : g_lo_direct
      assign lo_act = lo_cmp_i;
   end else begin : g_lo_invert
      assign lo_act = ~lo_cmp_i;
   end

   assign evt_mode = cfg_blank_mode ? EVT_WINDOW : EVT_EDGE;

   dtt_filter #(.W(FILT_W)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_len (cfg_filt_len),
      .din     (hi_cmp_i),
      .qual    (hi_qual)
   );

   dtt_sync_gen #(.WIN_W(WIN_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (lo_act),
      .mode    (evt_mode),
      .win_len (cfg_blank_len),
      .pulse   (sync_o)
   );

   dtt_trip_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (hi_qual),
      .clr   (sync_o),
      .q     (trip_o)
   );
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker (
   input logic clk,
   input logic rst_n,
   input logic hi_cmp_i,
   input logic hi_qual,
   input logic lo_act,
   input logic blank_mode,
   input logic sync_o,
   input logic trip_o
);
   // R2: filtered level only follows a sampled input value
   assert_qual_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_qual) |-> $past(hi_cmp_i));
   assert_qual_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hi_qual) |-> !$past(hi_cmp_i));
   assert_trip_needs_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_o) |-> $past(hi_qual));
   // R3: trip is sticky without a pulse
   assert_trip_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trip_o && !sync_o) |=> trip_o);
   // R4: no pulse unless the low-side condition was active
   assert_sync_needs_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_act |=> !sync_o);
   // R5: edge mode pulses are single-cycle
   assert_edge_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_o && !blank_mode) |=> !sync_o);
   // R8: pulse clears trip at the next edge
   assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !trip_o);
endmodule

bind dual_thresh_trip dtt_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hi_cmp_i   (hi_cmp_i),
   .hi_qual    (hi_qual),
   .lo_act     (lo_act),
   .blank_mode (cfg_blank_mode),
   .sync_o     (sync_o),
   .trip_o     (trip_o)
);

// File: tb/tb_dual_thresh_trip.sv
module tb_dual_thresh_trip;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_filt_len = 8'd4;
   logic        cfg_blank_mode = 1'b0;
   logic [15:0] cfg_blank_len = 16'd3;
   logic        hi_cmp_i = 1'b0;
   logic        lo_cmp_i = 1'b1;
   logic        trip_o;
   logic        sync_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   dual_thresh_trip dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_filt_len   (cfg_filt_len),
      .cfg_blank_mode (cfg_blank_mode),
      .cfg_blank_len  (cfg_blank_len),
      .hi_cmp_i       (hi_cmp_i),
      .lo_cmp_i       (lo_cmp_i),
      .trip_o         (trip_o),
      .sync_o         (sync_o)
   );

   // driver: one cycle of stimulus, expected {trip,sync} after the next edge
   task automatic step(input logic hi, input logic below,
                       input logic et, input logic es, input string tag);
      @(negedge clk);
      hi_cmp_i = hi;
      lo_cmp_i = ~below;
      exp_q.push_back({et, es});
      tag_q.push_back(tag);
   endtask

   // monitor: compares after each rising edge
   always begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
         logic [1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({trip_o, sync_o} !== e) begin
            errors++;
            $display("FAIL %s: actual trip=%b sync=%b expected trip=%b sync=%b",
                     t, trip_o, sync_o, e[1], e[0]);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset with every input asserting
      for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, "R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      hi_cmp_i = 1'b0;
      lo_cmp_i = 1'b1;

      // R2: a 3-sample high run with N=4 is rejected
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 short run");
      for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R2 short run");
      // R2: 4-sample run qualifies, trip on the 5th edge
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 qualify");
      step(1'b1, 1'b0, 1'b1, 1'b0, "R2 trip set");
      // R3: trip holds after high input drops
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R3 hold");
      // R4/R5: low-side active in edge mode
      step(1'b0, 1'b1, 1'b1, 1'b1, "R4 R5 edge pulse");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R8 cleared");
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "R5 static no repeat");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R4 inactive");
      // R8: clear wins over an asserted filtered input
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R2 requalify");
      step(1'b1, 1'b0, 1'b1, 1'b0, "R2 trip set again");
      step(1'b1, 1'b1, 1'b1, 1'b1, "R8 pulse with set");
      step(1'b1, 1'b1, 1'b0, 1'b0, "R8 clear wins");
      step(1'b1, 1'b1, 1'b1, 1'b0, "R5 no repeat, R2 re-set");
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R3 hold");

      // R6: window mode, L=3, period 4
      cfg_blank_mode = 1'b1;
      step(1'b0, 1'b1, 1'b1, 1'b1, "R6 first pulse");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6 repeat");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6 repeat");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R6 window");
      // R7: deactivate mid-window, reactivation fires at once
      step(1'b0, 1'b0, 1'b0, 1'b0, "R7 cancel");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R7 immediate pulse");
      step(1'b0, 1'b1, 1'b0, 1'b0, "R7 window");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R7 cancel");

      // R2: N=1, single high sample trips
      cfg_filt_len = 8'd1;
      step(1'b1, 1'b0, 1'b0, 1'b0, "R2 N1 qualify");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R2 N1 trip");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R3 N1 hold");
      // R6: L=0 pulses every cycle
      cfg_blank_len = 16'd0;
      step(1'b0, 1'b1, 1'b1, 1'b1, "R6 L0 pulse");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6 L0 pulse");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6 L0 pulse");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R4 inactive");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule